// File: doc/BRIEF.md
# Translation Lookaside Buffer with Lockdown Region

This block is a small, fully associative translation cache. It maps the virtual page of a lookup address to a physical page and returns the two-bit access permission of the addressed subpage. It has two kinds of slots: 32 normal slots, which a round-robin pointer replaces, and 8 locked slots, which that pointer never touches. When a lookup misses, the block raises a walk request. A separate walker answers it later through the refill port.

A preserve flag and a victim pointer sit in one software-visible control register. They decide where a refill lands. With the flag clear, a refill goes to the normal slot chosen by the round-robin pointer. With the flag set, it goes to the locked slot named by the victim pointer, and the victim pointer then advances. A locked entry maps the whole page when all four subpage permissions of the walked page agree. When they differ, it maps only the subpage that holds the address that triggered the walk.

Software can remove one translation with the single-entry invalidate. It can also clear every normal slot at once, and that leaves the locked slots as they are. A page is 4 KiB. It is split into four subpages, selected by address bits [11:10].

Top module: `tlb_lockdown`

## Requirements
- R1: When `lk_valid` is high at a clock edge, the next cycle shows `rsp_valid`=1. On a hit, `rsp_hit`=1 and `rsp_pa` = {stored physical page, `lk_va[11:0]`}. `rsp_ap` is the stored 2-bit permission of subpage `lk_va[11:10]`, where subpage k of a refill is `rf_ap[2k+1:2k]`. If several slots match, the lowest slot wins, numbering the normal slots 0..31 and the locked slots 32..39.
- R2: When a lookup misses, the next cycle shows `rsp_hit`=0, `walk_req`=1 and `walk_va` equal to the missed address. `walk_req` stays high until the clock edge at which `rf_valid` is high. A new miss at that same edge keeps it high.
- R3: `reg_rdata` bit 0 is the preserve flag and bits [28:26] are the victim pointer. All other bits read 0, and both fields reset to 0. A write through `reg_wr` shows up on `reg_rdata` one cycle later.
- R4: With the preserve flag clear, a refill goes to a normal slot chosen round-robin over the 32 normal slots. The victim pointer does not change.
- R5: With the preserve flag set, a refill goes to the locked slot named by the victim pointer. The pointer then advances by one and wraps from 7 to 0.
- R6: A locked refill whose four subpage permissions are not all equal maps only subpage `rf_va[11:10]` of the page. Lookups to the other subpages of that page miss.
- R7: A locked refill whose four subpage permissions are equal maps the whole page. A normal refill always maps the whole page.
- R8: `inv_valid` clears every slot that a lookup of `inv_va` would hit, so the next lookup of that address misses.
- R9: `inv_all` clears all normal slots. Locked slots keep hitting.
- R10: When a lookup and a refill happen in the same cycle, the lookup is resolved against the contents before the refill. If an invalidate and a refill happen in the same cycle, the refill's own slot ends valid.
- R11: Any number of normal refills leaves the locked entries in place.
- R12: When `reg_wr` and a locked refill happen in the same cycle, the written victim value wins over the automatic advance.

Port widths use the default parameters. An address is `ADDR_W` bits wide (default 32), a physical page number is `ADDR_W`−12 bits, and `reg_wdata` and `reg_rdata` are always 32 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_va | input | 32 | Lookup virtual address |
| rsp_valid | output | 1 | Lookup result present |
| rsp_hit | output | 1 | Lookup hit |
| rsp_pa | output | 32 | Translated physical address |
| rsp_ap | output | 2 | Access permission of the addressed subpage |
| walk_req | output | 1 | Page table walk wanted |
| walk_va | output | 32 | Address that missed |
| rf_valid | input | 1 | Refill from a completed walk |
| rf_va | input | 32 | Address that caused the walk |
| rf_ppn | input | 20 | Physical page number |
| rf_ap | input | 8 | Four 2-bit subpage permissions, subpage k at [2k+1:2k] |
| inv_valid | input | 1 | Invalidate entries matching `inv_va` |
| inv_va | input | 32 | Address to invalidate |
| inv_all | input | 1 | Invalidate all normal slots |
| reg_wr | input | 1 | Write the control register |
| reg_wdata | input | 32 | Control register write data |
| reg_rdata | output | 32 | Control register read data |

## Verification
Lookup results, the walk request and register writes all appear exactly one clock edge after their stimulus. A refill or an invalidate affects only lookups presented at later edges. The bench drives all inputs at the falling edge. It updates a reference model in the same order the design uses: lookup against the old contents, then invalidate, then refill, then the register. It compares every output at the following falling edge, so each result is read in the one cycle where it is due.

// File: rtl/tlb_lockdown.sv
module tlb_lockdown #(
  parameter int ADDR_W  = 32,
  parameter int OFS_W   = 12,
  parameter int NRM     = 32,
  parameter int LCK     = 8,
  parameter int VIC_LSB = 26
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    lk_valid,
  input  logic [ADDR_W-1:0]       lk_va,
  output logic                    rsp_valid,
  output logic                    rsp_hit,
  output logic [ADDR_W-1:0]       rsp_pa,
  output logic [1:0]              rsp_ap,
  output logic                    walk_req,
  output logic [ADDR_W-1:0]       walk_va,
  input  logic                    rf_valid,
  input  logic [ADDR_W-1:0]       rf_va,
  input  logic [ADDR_W-OFS_W-1:0] rf_ppn,
  input  logic [7:0]              rf_ap,
  input  logic                    inv_valid,
  input  logic [ADDR_W-1:0]       inv_va,
  input  logic                    inv_all,
  input  logic                    reg_wr,
  input  logic [31:0]             reg_wdata,
  output logic [31:0]             reg_rdata
);
  localparam int N     = NRM + LCK;
  localparam int PG_W  = ADDR_W - OFS_W;
  localparam int IDX_W = $clog2(N);
  localparam int RR_W  = $clog2(NRM);
  localparam int VIC_W = $clog2(LCK);

  logic [N-1:0]      val, so, lk_m, inv_m;
  logic [PG_W-1:0]   e_vpn [N];
  logic [PG_W-1:0]   e_ppn [N];
  logic [1:0]        e_sub [N];
  logic [7:0]        e_ap  [N];
  logic              pre;
  logic [VIC_W-1:0]  vic;
  logic [RR_W-1:0]   rr;
  logic [IDX_W-1:0]  hidx, widx;

  wire [1:0] lk_sub  = lk_va[OFS_W-1 -: 2];
  wire [1:0] inv_sub = inv_va[OFS_W-1 -: 2];
  wire       uniform = (rf_ap[1:0] == rf_ap[3:2]) && (rf_ap[1:0] == rf_ap[5:4]) &&
                       (rf_ap[1:0] == rf_ap[7:6]);
  wire       miss    = lk_valid && !(|lk_m);

  assign widx = pre ? IDX_W'(NRM) + IDX_W'(vic) : IDX_W'(rr);

  always_comb begin
    for (int i = 0; i < N; i++) begin
      lk_m[i]  = val[i] && e_vpn[i] == lk_va[ADDR_W-1:OFS_W] && (!so[i] || e_sub[i] == lk_sub);
      inv_m[i] = val[i] && e_vpn[i] == inv_va[ADDR_W-1:OFS_W] && (!so[i] || e_sub[i] == inv_sub);
    end
    hidx = '0;
    for (int i = N - 1; i >= 0; i--)
      if (lk_m[i]) hidx = IDX_W'(i);
  end

  always_comb begin
    reg_rdata = '0;
    reg_rdata[0] = pre;
    reg_rdata[VIC_LSB +: VIC_W] = vic;
  end

  always_ff @(posedge clk) begin
    if (rf_valid) begin
      e_vpn[widx] <= rf_va[ADDR_W-1:OFS_W];
      e_ppn[widx] <= rf_ppn;
      e_sub[widx] <= rf_va[OFS_W-1 -: 2];
      e_ap[widx]  <= rf_ap;
      so[widx]    <= pre && !uniform;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      val       <= '0;
      pre       <= 1'b0;
      vic       <= '0;
      rr        <= '0;
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_pa    <= '0;
      rsp_ap    <= '0;
      walk_req  <= 1'b0;
      walk_va   <= '0;
    end else begin
      for (int i = 0; i < N; i++)
        if ((inv_all && i < NRM) || (inv_valid && inv_m[i])) val[i] <= 1'b0;
      if (rf_valid) begin
        val[widx] <= 1'b1;
        if (!pre) rr <= (rr == RR_W'(NRM - 1)) ? '0 : rr + 1'b1;
      end
      if (reg_wr) begin
        pre <= reg_wdata[0];
        vic <= reg_wdata[VIC_LSB +: VIC_W];
      end else if (rf_valid && pre) begin
        vic <= (vic == VIC_W'(LCK - 1)) ? '0 : vic + 1'b1;
      end
      rsp_valid <= lk_valid;
      rsp_hit   <= lk_valid && |lk_m;
      rsp_pa    <= {e_ppn[hidx], lk_va[OFS_W-1:0]};
      rsp_ap    <= e_ap[hidx][{lk_sub, 1'b0} +: 2];
      if (miss) begin
        walk_req <= 1'b1;
        walk_va  <= lk_va;
      end else if (rf_valid) begin
        walk_req <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/tlb_lockdown_chk.sv
module tlb_lockdown_chk #(
  parameter int VIC_LSB = 26,
  parameter int VIC_W   = 3
) (
  input logic        clk,
  input logic        rst_n,
  input logic        lk_valid,
  input logic        rsp_valid,
  input logic        rsp_hit,
  input logic        walk_req,
  input logic        rf_valid,
  input logic        reg_wr,
  input logic [31:0] reg_wdata,
  input logic [31:0] reg_rdata
);
  localparam logic [31:0] MASK = (((32'd1 << VIC_W) - 32'd1) << VIC_LSB) | 32'd1;

  a_r1_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> rsp_valid);
  a_r1_no_hit_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> !rsp_hit);
  a_r2_miss_walks: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_hit |-> walk_req);
  a_r2_walk_holds: assert property (@(posedge clk) disable iff (!rst_n)
    walk_req && !rf_valid |=> walk_req);
  a_r3_reg_write: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> reg_rdata == ($past(reg_wdata) & MASK));
  a_r3_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata & ~MASK) == 32'd0);
  a_r4_victim_still: assert property (@(posedge clk) disable iff (!rst_n)
    rf_valid && !reg_rdata[0] && !reg_wr |=> $stable(reg_rdata));
  a_r5_victim_step: assert property (@(posedge clk) disable iff (!rst_n)
    rf_valid && reg_rdata[0] && !reg_wr |=>
      reg_rdata[VIC_LSB +: VIC_W] == VIC_W'($past(reg_rdata[VIC_LSB +: VIC_W]) + 1'b1));
endmodule

bind tlb_lockdown tlb_lockdown_chk u_chk (.*);

// File: tb/sim_tlb_lockdown.sv
module sim_tlb_lockdown;
  logic clk = 0, rst_n = 0;
  logic lk_valid = 0, rf_valid = 0, inv_valid = 0, inv_all = 0, reg_wr = 0;
  logic [31:0] lk_va = 0, rf_va = 0, inv_va = 0, reg_wdata = 0;
  logic [19:0] rf_ppn = 0;
  logic [7:0]  rf_ap = 0;
  logic rsp_valid, rsp_hit, walk_req;
  logic [31:0] rsp_pa, walk_va, reg_rdata;
  logic [1:0] rsp_ap;

  tlb_lockdown u0 (.*);

  always #2 clk = ~clk;

  int nchk = 0, nerr = 0;
  bit done = 0;

  bit         mv [40];
  bit         mso[40];
  logic [19:0] mvpn[40], mppn[40];
  logic [1:0]  msub[40];
  logic [7:0]  map[40];
  bit          mpre = 0, mwalk = 0;
  int          mvic = 0, mrr = 0;
  logic [31:0] mwva = 0;

  function automatic bit hits(int i, logic [31:0] va);
    return mv[i] && mvpn[i] == va[31:12] && (!mso[i] || msub[i] == va[11:10]);
  endfunction

  function automatic int find(logic [31:0] va);
    for (int i = 0; i < 40; i++) if (hits(i, va)) return i;
    return -1;
  endfunction

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(string req);
    int   hi;
    bit   do_lk;
    logic [31:0] e_pa, va;
    logic [1:0]  e_ap;
    do_lk = lk_valid; va = lk_va;
    hi = do_lk ? find(lk_va) : -1;
    if (hi >= 0) begin
      e_pa = {mppn[hi], lk_va[11:0]};
      e_ap = map[hi][{lk_va[11:10], 1'b0} +: 2];
    end else begin
      e_pa = 0; e_ap = 0;
    end
    if (do_lk && hi < 0) begin mwalk = 1; mwva = lk_va; end
    else if (rf_valid) mwalk = 0;
    for (int i = 0; i < 40; i++)
      if ((inv_all && i < 32) || (inv_valid && hits(i, inv_va))) mv[i] = 0;
    if (rf_valid) begin
      int k;
      bit uni;
      k = mpre ? 32 + mvic : mrr;
      uni = rf_ap[1:0] == rf_ap[3:2] && rf_ap[1:0] == rf_ap[5:4] && rf_ap[1:0] == rf_ap[7:6];
      mv[k] = 1; mvpn[k] = rf_va[31:12]; mppn[k] = rf_ppn; msub[k] = rf_va[11:10];
      map[k] = rf_ap; mso[k] = mpre && !uni;
      if (!mpre) mrr = (mrr + 1) % 32;
    end
    if (reg_wr) begin mpre = reg_wdata[0]; mvic = int'(reg_wdata[28:26]); end
    else if (rf_valid && mpre) mvic = (mvic + 1) % 8;
    @(posedge clk);
    @(negedge clk);
    if (do_lk) begin
      chk(rsp_valid === 1'b1, "R1", {63'd0, rsp_valid}, 64'd1);
      chk(rsp_hit === (hi >= 0), hi >= 0 ? req : "R2", {63'd0, rsp_hit}, {63'd0, hi >= 0});
      if (hi >= 0) begin
        chk(rsp_pa === e_pa, req, {32'd0, rsp_pa}, {32'd0, e_pa});
        chk(rsp_ap === e_ap, req, {62'd0, rsp_ap}, {62'd0, e_ap});
      end
    end
    chk(walk_req === mwalk, "R2", {63'd0, walk_req}, {63'd0, mwalk});
    if (mwalk) chk(walk_va === mwva, "R2", {32'd0, walk_va}, {32'd0, mwva});
    chk(reg_rdata === {3'b0, 3'(mvic), 25'b0, mpre}, "R3", {32'd0, reg_rdata},
        {32'd0, 3'b0, 3'(mvic), 25'b0, mpre});
    lk_valid = 0; rf_valid = 0; inv_valid = 0; inv_all = 0; reg_wr = 0;
  endtask

  task automatic look(logic [31:0] va, string req);
    lk_valid = 1; lk_va = va; step(req);
  endtask

  task automatic refill(logic [31:0] va, logic [19:0] ppn, logic [7:0] ap, string req);
    rf_valid = 1; rf_va = va; rf_ppn = ppn; rf_ap = ap; step(req);
  endtask

  task automatic wreg(logic [31:0] d);
    reg_wr = 1; reg_wdata = d; step("R3");
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog expired");
      $display("  Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 40; i++) mv[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk(reg_rdata === 0 && walk_req === 0 && rsp_valid === 0, "R3 reset",
        {32'd0, reg_rdata}, 64'd0);

    look(32'h0000_5400, "R2");
    refill(32'h0000_5400, 20'hABCDE, 8'hFF, "R4");
    look(32'h0000_5C10, "R7");

    wreg({3'b0, 3'd7, 25'b0, 1'b1});
    refill(32'h0000_7800, 20'h11111, 8'b11_10_01_00, "R6");
    look(32'h0000_7804, "R6");
    look(32'h0000_7404, "R6");
    refill(32'h0000_8000, 20'h22222, 8'h55, "R5");
    look(32'h0000_8C00, "R7");

    wreg(32'h0);
    for (int i = 0; i < 33; i++) refill({12'h100, 8'(i), 12'h0}, 20'(i), 8'hAA, "R4");
    look(32'h0000_7820, "R11");
    look(32'h0000_8400, "R11");
    look(32'h1000_3000, "R4");
    inv_all = 1; step("R9");
    look(32'h1000_3000, "R9");
    look(32'h0000_8004, "R9");
    inv_valid = 1; inv_va = 32'h0000_8123; step("R8");
    look(32'h0000_8123, "R8");

    lk_valid = 1; lk_va = 32'h0000_9000;
    rf_valid = 1; rf_va = 32'h0000_9000; rf_ppn = 20'h33333; rf_ap = 8'h00; step("R10");
    look(32'h0000_9004, "R10");
    inv_valid = 1; inv_va = 32'h0000_9000;
    rf_valid = 1; rf_va = 32'h0000_9000; rf_ppn = 20'h44444; rf_ap = 8'hFF; step("R10");
    look(32'h0000_9008, "R10");

    wreg({3'b0, 3'd2, 25'b0, 1'b1});
    reg_wr = 1; reg_wdata = {3'b0, 3'd5, 25'b0, 1'b1};
    rf_valid = 1; rf_va = 32'h0000_A000; rf_ppn = 20'h55555; rf_ap = 8'h00; step("R12");
    refill(32'h0000_B000, 20'h66666, 8'h0F, "R5");
    wreg(32'hFFFF_FFFE);

    for (int n = 0; n < 4000; n++) begin
      int r;
      r = int'($urandom_range(0, 99));
      if (r < 60) begin lk_valid = 1; lk_va = {12'h0, 8'($urandom_range(0, 11)), 12'($urandom)}; end
      r = int'($urandom_range(0, 99));
      if (r < 20) begin
        rf_valid = 1;
        rf_va = {12'h0, 8'($urandom_range(0, 11)), 12'($urandom)};
        rf_ppn = 20'($urandom);
        rf_ap = ($urandom_range(0, 1) == 1) ? {4{2'($urandom)}} : 8'($urandom);
      end
      r = int'($urandom_range(0, 99));
      if (r < 5) begin inv_valid = 1; inv_va = {12'h0, 8'($urandom_range(0, 11)), 12'($urandom)}; end
      if (r == 50) inv_all = 1;
      r = int'($urandom_range(0, 99));
      if (r < 4) begin reg_wr = 1; reg_wdata = $urandom; end
      step(rf_valid ? "R5" : "R1");
    end

    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule